// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM alive on behalf of an access controller. It starts after reset. It holds the strobes idle for a programmable power-up pause and then runs eight wake-up refresh cycles by itself. Only after that does it tell the controller that the memory is usable. From then on it counts clock ticks and raises a refresh request at a fixed interval. The interval is chosen so that every row of the array is refreshed inside the retention period. The default values fit 1024 rows in 16 ms at 100 MHz, less a safety margin.

The access controller answers a request with a grant. For the whole of the refresh cycle that follows, the sequencer owns the row strobe, both column strobes and the address bus. Each refresh cycle runs in one of two forms. CAS-before-RAS refresh drops both column strobes ahead of the row strobe. Row-only refresh keeps the column strobes high and drives a row address taken from an internal counter. A mode pin selects the form, and the block samples it as each cycle begins. If a request waits past a hard deadline without a grant, the block pulses an overdue flag, withdraws ready and repeats the eight-cycle wake-up.

The clock rate, the pause, the refresh period, the strobe timings and the deadline are all parameters. Every timing becomes a whole number of clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted and during the PAUSE_CYC cycles after it is released, ras_n_o is 1, cas_n_o is 2'b11, ready_o, req_o and overdue_o are 0, and own_o is 1.
- R2: After the pause, the block runs exactly eight refresh cycles with no grant needed. ready_o rises in the cycle after the precharge of the eighth cycle ends.
- R3: In CAS-before-RAS mode (ras_only_i = 0 when the cycle starts), cas_n_o is 2'b00 for LEAD_CYC cycles before ras_n_o falls. It stays 2'b00 through the whole RAS-low phase and returns to 2'b11 together with ras_n_o. we_n_o is always 1.
- R4: In row-only mode (ras_only_i = 1 when the cycle starts), cas_n_o stays 2'b11. addr_o carries the row counter value, unchanged, for the whole refresh cycle. When no refresh cycle is active, addr_o is 0, and it is also 0 during a CAS-before-RAS cycle.
- R5: Each refresh cycle holds ras_n_o low for exactly LOW_CYC cycles. It is followed by PRE_CYC precharge cycles and at least one idle cycle before the next cycle's lead phase.
- R6: The row counter starts at 0 after reset. It increments after each completed row-only cycle and wraps from 2**ROW_W-1 (1023 by default) to 0. A CAS-before-RAS cycle leaves it unchanged.
- R7: Once ready, req_o rises every INTERVAL_CYC cycles, counted from the first ready cycle. It stays high until the block starts a refresh cycle, and it is 0 whenever ready_o is 0.
- R8: A refresh cycle's lead phase begins in the cycle after one in which req_o and gnt_i are both high. gnt_i has no effect while req_o is low.
- R9: If req_o has been high for DEADLINE_CYC cycles with no grant, overdue_o pulses for one cycle and ready_o falls in that same cycle. The eight-cycle wake-up then repeats without a new pause, and ready_o rises again afterwards.
- R10: own_o is 1 during the pause, during the wake-up, and during every cycle of a granted refresh cycle. It is 0 at all other times.
- R11: ras_only_i is sampled only when a refresh cycle starts. Changing it while a cycle is in progress does not change that cycle's strobes or address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_only_i | input | 1 | Refresh form for the next cycle: 1 row-only, 0 CAS-before-RAS |
| gnt_i | input | 1 | Grant from the access controller |
| req_o | output | 1 | Refresh request to the access controller |
| ready_o | output | 1 | Memory initialised and usable |
| overdue_o | output | 1 | One-cycle pulse when a request misses its deadline |
| own_o | output | 1 | Sequencer currently drives the DRAM strobes and address |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 2 | Upper and lower column strobes, active low |
| we_n_o | output | 1 | Write enable, held high |
| addr_o | output | ROW_W | Row address for row-only refresh |

## Verification
The bench aims at the points where the strobes change relative to each other. A design that let the column strobes fall in the same cycle as the row strobe would break CAS-before-RAS setup. A design that changed the address during RAS-low would refresh the wrong row. The row counter is run through its wrap. A counter of the wrong width, or one that also advanced on CAS-before-RAS cycles, would then put a wrong address on the bus. The grant is withheld long enough to force the deadline. A design that failed to drop ready, or that inserted a second power-up pause, would then fall out of step with the reference model. The mode pin and the grant are also toggled every cycle, so a design that re-sampled the mode mid-cycle, or honoured a stray grant, shows up as a strobe mismatch.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {
    SEQ_PAUSE = 2'd0,
    SEQ_WAKE  = 2'd1,
    SEQ_READY = 2'd2
  } seq_st_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_LOW  = 2'd2,
    PH_PRE  = 2'd3
  } ph_e;

  localparam int WAKE_CYCLES = 8;
endpackage

// File: rtl/rfsh_strobe_gen.sv
module rfsh_strobe_gen
  import rfsh_pkg::*;
#(
  parameter int LEAD_CYC = 1,
  parameter int LOW_CYC  = 6,
  parameter int PRE_CYC  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic mode_ro_i,
  output logic busy_o,
  output logic done_o,
  output logic mode_o,
  output logic ras_n_o,
  output logic cas_act_o
);
  localparam int MAXC  = (LEAD_CYC > LOW_CYC) ? ((LEAD_CYC > PRE_CYC) ? LEAD_CYC : PRE_CYC)
                                              : ((LOW_CYC > PRE_CYC) ? LOW_CYC : PRE_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);

  ph_e              ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mode_q, mode_d;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    unique case (ph_q)
      PH_IDLE: if (start_i) begin
        ph_d   = PH_LEAD;
        cnt_d  = '0;
        mode_d = mode_ro_i;
      end
      PH_LEAD: if (cnt_q == CNT_W'(LEAD_CYC - 1)) begin
        ph_d  = PH_LOW;
        cnt_d = '0;
      end else cnt_d = cnt_q + 1'b1;
      PH_LOW: if (cnt_q == CNT_W'(LOW_CYC - 1)) begin
        ph_d  = PH_PRE;
        cnt_d = '0;
      end else cnt_d = cnt_q + 1'b1;
      PH_PRE: if (cnt_q == CNT_W'(PRE_CYC - 1)) begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end else cnt_d = cnt_q + 1'b1;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
    end
  end

  assign busy_o    = (ph_q != PH_IDLE);
  assign done_o    = (ph_q == PH_PRE) && (cnt_q == CNT_W'(PRE_CYC - 1));
  assign mode_o    = mode_q;
  assign ras_n_o   = (ph_q != PH_LOW);
  assign cas_act_o = !mode_q && ((ph_q == PH_LEAD) || (ph_q == PH_LOW));
endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [ROW_W-1:0] row_o
);
  logic [ROW_W-1:0] row_q, row_d;

  always_comb begin
    row_d = row_q;
    if (inc_i) row_d = row_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else        row_q <= row_d;
  end

  assign row_o = row_q;
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched #(
  parameter int INTERVAL_CYC = 1500,
  parameter int DEADLINE_CYC = 750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic start_i,
  output logic req_o,
  output logic late_o
);
  localparam int INT_W = $clog2(INTERVAL_CYC + 1);
  localparam int DL_W  = $clog2(DEADLINE_CYC + 1);

  logic [INT_W-1:0] int_q, int_d;
  logic [DL_W-1:0]  dl_q, dl_d;
  logic             pend_q, pend_d;
  logic             wrap;

  always_comb begin
    wrap   = run_i && (int_q == INT_W'(INTERVAL_CYC - 1));
    late_o = run_i && pend_q && !start_i && (dl_q == DL_W'(DEADLINE_CYC - 1));
    int_d  = (!run_i || wrap) ? '0 : int_q + 1'b1;
    dl_d   = (run_i && pend_q && !start_i) ? dl_q + 1'b1 : '0;
    if (!run_i || late_o) pend_d = 1'b0;
    else if (wrap)        pend_d = 1'b1;
    else if (start_i)     pend_d = 1'b0;
    else                  pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q  <= '0;
      dl_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      int_q  <= int_d;
      dl_q   <= dl_d;
      pend_q <= pend_d;
    end
  end

  assign req_o = pend_q;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import rfsh_pkg::*;
#(
  parameter int CLK_MHZ      = 100,
  parameter int PAUSE_US     = 200,
  parameter int REFRESH_MS   = 16,
  parameter int ROW_W        = 10,
  parameter int MARGIN_CYC   = 62,
  parameter int T_LEAD_NS    = 10,
  parameter int T_LOW_NS     = 60,
  parameter int T_PRE_NS     = 40,
  parameter int PAUSE_CYC    = CLK_MHZ * PAUSE_US,
  parameter int INTERVAL_CYC = (CLK_MHZ * REFRESH_MS * 1000) / (1 << ROW_W) - MARGIN_CYC,
  parameter int DEADLINE_CYC = INTERVAL_CYC / 2,
  parameter int LEAD_CYC     = (T_LEAD_NS * CLK_MHZ + 999) / 1000,
  parameter int LOW_CYC      = (T_LOW_NS * CLK_MHZ + 999) / 1000,
  parameter int PRE_CYC      = (T_PRE_NS * CLK_MHZ + 999) / 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_only_i,
  input  logic             gnt_i,
  output logic             req_o,
  output logic             ready_o,
  output logic             overdue_o,
  output logic             own_o,
  output logic             ras_n_o,
  output logic [1:0]       cas_n_o,
  output logic             we_n_o,
  output logic [ROW_W-1:0] addr_o
);
  localparam int PAUSE_W = $clog2(PAUSE_CYC + 1);
  localparam int WAKE_W  = $clog2(WAKE_CYCLES);

  seq_st_e            st_q, st_d;
  logic [PAUSE_W-1:0] pause_q, pause_d;
  logic [WAKE_W-1:0]  wake_q, wake_d;
  logic               overdue_q;
  logic               eng_busy, eng_done, eng_mode, eng_ras_n, cas_act;
  logic               start, late, run;
  logic [ROW_W-1:0]   row;

  assign run   = (st_q == SEQ_READY);
  assign start = !eng_busy && ((st_q == SEQ_WAKE) || (run && req_o && gnt_i));

  always_comb begin
    st_d    = st_q;
    pause_d = pause_q;
    wake_d  = wake_q;
    unique case (st_q)
      SEQ_PAUSE: if (pause_q == PAUSE_W'(PAUSE_CYC - 1)) begin
        st_d   = SEQ_WAKE;
        wake_d = '0;
      end else pause_d = pause_q + 1'b1;
      SEQ_WAKE: if (eng_done) begin
        if (wake_q == WAKE_W'(WAKE_CYCLES - 1)) st_d = SEQ_READY;
        else wake_d = wake_q + 1'b1;
      end
      SEQ_READY: if (late) begin
        st_d   = SEQ_WAKE;
        wake_d = '0;
      end
      default: st_d = SEQ_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SEQ_PAUSE;
      pause_q   <= '0;
      wake_q    <= '0;
      overdue_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      pause_q   <= pause_d;
      wake_q    <= wake_d;
      overdue_q <= late;
    end
  end

  rfsh_strobe_gen #(
    .LEAD_CYC (LEAD_CYC),
    .LOW_CYC  (LOW_CYC),
    .PRE_CYC  (PRE_CYC)
  ) u_strobe (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .mode_ro_i (ras_only_i),
    .busy_o    (eng_busy),
    .done_o    (eng_done),
    .mode_o    (eng_mode),
    .ras_n_o   (eng_ras_n),
    .cas_act_o (cas_act)
  );

  rfsh_row_ctr #(.ROW_W(ROW_W)) u_row (
    .clk   (clk),
    .rst_n (rst_n),
    .inc_i (eng_done && eng_mode),
    .row_o (row)
  );

  rfsh_sched #(
    .INTERVAL_CYC (INTERVAL_CYC),
    .DEADLINE_CYC (DEADLINE_CYC)
  ) u_sched (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run),
    .start_i (start),
    .req_o   (req_o),
    .late_o  (late)
  );

  assign ready_o   = run;
  assign overdue_o = overdue_q;
  assign own_o     = !run || eng_busy;
  assign ras_n_o   = eng_ras_n;
  assign cas_n_o   = {2{~cas_act}};
  assign we_n_o    = 1'b1;
  assign addr_o    = (eng_busy && eng_mode) ? row : '0;
endmodule

// File: rtl/rfsh_seq_checks.sv
module rfsh_seq_checks #(
  parameter int ROW_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gnt_i,
  input logic             req_o,
  input logic             ready_o,
  input logic             overdue_o,
  input logic             own_o,
  input logic             ras_n_o,
  input logic [1:0]       cas_n_o,
  input logic [ROW_W-1:0] addr_o
);
  AST_CAS_SETTLED_AT_RAS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |-> $stable(cas_n_o)); // R3

  AST_CAS_PAIR_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n_o == 2'b00) || (cas_n_o == 2'b11)); // R3

  AST_ROW_HELD_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n_o && $past(!ras_n_o)) |-> $stable(addr_o)); // R4

  AST_STROBE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n_o || (cas_n_o != 2'b11)) |-> own_o); // R10

  AST_NO_REQ_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> !req_o); // R7

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !gnt_i) |=> (req_o || overdue_o)); // R7

  AST_OVERDUE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    overdue_o |-> !ready_o); // R9
endmodule

bind dram_refresh_seq rfsh_seq_checks #(.ROW_W(ROW_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .gnt_i     (gnt_i),
  .req_o     (req_o),
  .ready_o   (ready_o),
  .overdue_o (overdue_o),
  .own_o     (own_o),
  .ras_n_o   (ras_n_o),
  .cas_n_o   (cas_n_o),
  .addr_o    (addr_o)
);

// File: tb/dram_refresh_seq_bench.sv
module dram_refresh_seq_bench;
  localparam int ROW_W = 10;
  localparam int PAUSE = 30;
  localparam int INTV  = 24;
  localparam int DL    = 10;
  localparam int LD    = 1;
  localparam int RL    = 6;
  localparam int PR    = 4;
  localparam int TOT   = LD + RL + PR;

  logic             clk, rst_n, ras_only, gnt;
  logic             req_o, ready_o, overdue_o, own_o, ras_n_o, we_n_o;
  logic [1:0]       cas_n_o;
  logic [ROW_W-1:0] addr_o;

  dram_refresh_seq #(
    .ROW_W(ROW_W), .PAUSE_CYC(PAUSE), .INTERVAL_CYC(INTV), .DEADLINE_CYC(DL),
    .LEAD_CYC(LD), .LOW_CYC(RL), .PRE_CYC(PR)
  ) u_dram_refresh_seq (
    .clk(clk), .rst_n(rst_n), .ras_only_i(ras_only), .gnt_i(gnt),
    .req_o(req_o), .ready_o(ready_o), .overdue_o(overdue_o), .own_o(own_o),
    .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o), .addr_o(addr_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // behavioural reference model
  int m_st, m_pause, m_wake, m_eng, m_row, m_int, m_dl;
  bit m_ro, m_pend, m_over, s, d, late, wrap;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_pause = 0; m_wake = 0; m_eng = -1; m_ro = 0; m_row = 0;
      m_int = 0; m_pend = 0; m_dl = 0; m_over = 0;
    end else begin
      s    = (m_eng < 0) && (m_st == 1 || (m_st == 2 && m_pend && gnt));
      d    = (m_eng == TOT - 1);
      late = (m_st == 2) && m_pend && !s && (m_dl == DL - 1);
      wrap = (m_st == 2) && (m_int == INTV - 1);
      m_over = late;
      if (d && m_ro) m_row = (m_row + 1) % (1 << ROW_W);
      if (d) m_eng = -1;
      else if (m_eng >= 0) m_eng = m_eng + 1;
      else if (s) begin m_eng = 0; m_ro = ras_only; end
      if (m_st == 2) begin
        m_dl = (m_pend && !s) ? m_dl + 1 : 0;
        if (late) m_pend = 0;
        else if (wrap) m_pend = 1;
        else if (s) m_pend = 0;
        m_int = wrap ? 0 : m_int + 1;
      end else begin
        m_dl = 0; m_pend = 0; m_int = 0;
      end
      case (m_st)
        0: if (m_pause == PAUSE - 1) begin m_st = 1; m_wake = 0; end
           else m_pause = m_pause + 1;
        1: if (d) begin
             if (m_wake == 7) m_st = 2;
             else m_wake = m_wake + 1;
           end
        default: if (late) begin m_st = 1; m_wake = 0; end
      endcase
    end
  end

  // compare every cycle, plus event monitors
  bit prev_ras = 1, prev_ready = 0, wrap_seen = 0;
  int falls = 0, over_seen = 0, last_row = -1;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit e_low;
      int e_cas, e_addr;
      e_low  = (m_eng >= LD) && (m_eng < LD + RL);
      e_cas  = (m_eng >= 0 && m_eng < LD + RL && !m_ro) ? 0 : 3;
      e_addr = (m_eng >= 0 && m_ro) ? m_row : 0;
      chk(ras_n_o === !e_low, "R5 R8 ras_n", ras_n_o, !e_low);
      chk(cas_n_o === 2'(e_cas), "R3 R11 cas_n", cas_n_o, e_cas);
      chk(we_n_o === 1'b1, "R3 we_n", we_n_o, 1);
      chk(addr_o === ROW_W'(e_addr), "R4 R6 addr", addr_o, e_addr);
      chk(req_o === m_pend, "R7 R8 req", req_o, m_pend);
      chk(ready_o === (m_st == 2), "R1 R2 R9 ready", ready_o, m_st == 2);
      chk(overdue_o === m_over, "R9 overdue", overdue_o, m_over);
      chk(own_o === (m_st != 2 || m_eng >= 0), "R10 own", own_o, m_st != 2 || m_eng >= 0);

      if (overdue_o) begin falls = 0; over_seen++; end
      if (prev_ras && !ras_n_o) begin
        falls++;
        if (cas_n_o == 2'b11) begin
          if (last_row == (1 << ROW_W) - 1 && addr_o == '0) wrap_seen = 1;
          last_row = addr_o;
        end
      end
      if (ready_o && !prev_ready) chk(falls == 8, "R2 R9 wake-up count", falls, 8);
      prev_ras   = ras_n_o;
      prev_ready = ready_o;
    end else if (!rst_n) begin
      falls = 0; prev_ras = 1; prev_ready = 0;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      chk(0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    rst_n = 0; gnt = 0; ras_only = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(ras_n_o === 1'b1, "R1 ras_n in reset", ras_n_o, 1);
    chk(cas_n_o === 2'b11, "R1 cas_n in reset", cas_n_o, 3);
    chk(ready_o === 1'b0, "R1 ready in reset", ready_o, 0);
    chk(req_o === 1'b0, "R1 req in reset", req_o, 0);
    chk(overdue_o === 1'b0, "R1 overdue in reset", overdue_o, 0);
    chk(own_o === 1'b1, "R1 own in reset", own_o, 1);
    rst_n = 1;
    // CAS-before-RAS wake-up, grant ignored while not ready
    gnt = 1;
    wait (ready_o);
    @(negedge clk);
    // row-only refresh long enough to wrap the row counter
    ras_only = 1;
    repeat (1040 * INTV) @(negedge clk);
    // CAS-before-RAS refreshes must not move the row counter
    ras_only = 0;
    repeat (10 * INTV) @(negedge clk);
    // withhold grant to force the deadline
    ras_only = 1;
    gnt = 0;
    repeat (3 * INTV) @(negedge clk);
    gnt = 1;
    wait (ready_o);
    @(negedge clk);
    // random grant and mode toggling
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      gnt = ($urandom % 4) != 0;
      ras_only = $urandom % 2;
    end
    gnt = 1;
    repeat (4 * INTV) @(negedge clk);
    chk(wrap_seen, "R6 row wrap observed", wrap_seen, 1);
    chk(over_seen > 0, "R9 overdue observed", over_seen, 1);
    finish_run();
  end
endmodule